// File: doc/BRIEF.md
# Multi-line stereo serial audio port

This block carries stereo audio samples between external converters and on-chip processors. It has several transmit data lines and several receive data lines. All of them share one bit clock and one word clock, so every line moves its left and right samples in the same bit periods. Samples are 24 bits wide and travel MSB first. The first data bit follows the word-clock transition by one bit clock. A low word clock marks the left channel and a high word clock marks the right channel. Outgoing bits change on the falling bit-clock edge, and incoming bits are taken on the rising edge.

The bit clock and word clock normally arrive from outside and are oversampled by the system clock. One control bit switches the port to generate both clocks itself, divided down from the system clock, and to drive them out with an output enable.

Each line has a left and a right register. Software fills the transmit pairs and empties the receive pairs. It is told once per stereo pair, through one transmit interrupt and one receive interrupt. Several processor masters share the register port through a fixed-priority arbiter.

Top module: `stereo_audio_port`

## Requirements
- R1: After reset the following are all 0: sck_o, ws_o, clk_oe, tx_sd, tx_irq, rx_irq, hgnt and hrvalid. A read of STATUS returns 0x1.
- R2: When several masters request, only the lowest-index requester is granted, in the same cycle. Its access is performed and the others are ignored. Read data appears on hrdata one cycle after the grant, and hrvalid is raised only for that master.
- R3: The register word addresses are as follows. CTRL is at 0, with bit0 transmit enable, bit1 receive enable, bit2 clock master, bit3 transmit interrupt enable and bit4 receive interrupt enable. STATUS is at 1, with bit0 transmit-pair request, bit1 receive-pair ready, bit2 underrun and bit3 overrun. Transmit line i has its left register at 8+2i and its right register at 9+2i. Receive line j has its left register at 32+2j and its right register at 33+2j. Sample registers use bits 23:0.
- R4: Each transmit word is launched MSB first on falling bit-clock edges. Its MSB occupies the second bit period after the word-clock change. The 24 bits are followed by zeros until the next word. Word clock low carries left and high carries right.
- R5: Receive lines capture 24 bits MSB first on rising bit-clock edges, starting in the second bit period after the word-clock change. The left word goes to the left register and the right word to the right register.
- R6: All transmit lines and all receive lines move their samples in the same bit periods.
- R7: At the start of each left word, the left and right registers of every transmit line are copied together for that pair, and the transmit-pair request is set. A write to the right register of the last transmit line clears the request.
- R8: If the transmit-pair request is still set when a pair is copied, the underrun flag sets and the unchanged register contents are sent again.
- R9: Receive-pair ready sets when the right word of a pair completes. A read of the right register of the last receive line clears it.
- R10: If a pair completes while receive-pair ready is still set, the overrun flag sets and the new pair replaces the old one.
- R11: A read of STATUS returns both flags and then clears the underrun and overrun flags.
- R12: tx_irq equals the transmit interrupt enable AND the transmit-pair request. rx_irq equals the receive interrupt enable AND receive-pair ready.
- R13: With the clock-master bit set, clk_oe is 1 and sck_o toggles every DIV system clocks. ws_o changes together with a falling sck_o edge every SLOT bit clocks, and the port runs from these clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hreq | input | NM | Access request per master |
| hwe | input | NM | Write (1) or read (0) per master |
| haddr | input | NM*AW | Word address per master |
| hwdata | input | NM*32 | Write data per master |
| hgnt | output | NM | Grant, one-hot |
| hrvalid | output | NM | Read data valid for the granted reader |
| hrdata | output | 32 | Read data |
| tx_irq | output | 1 | Transmit pair interrupt |
| rx_irq | output | 1 | Receive pair interrupt |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word clock |
| sck_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Generated word clock |
| clk_oe | output | 1 | Enable for driving sck_o and ws_o |
| tx_sd | output | NTX | Transmit data lines |
| rx_sd | input | NRX | Receive data lines |

## Verification
Register reads are due on the cycle after the grant. The bench drives each access at a falling system-clock edge and samples hrdata at the next falling edge, after one rising edge has registered the data. In slave mode a transmit bit reaches its pin three system clocks after the external falling edge: two synchroniser stages plus the shift register. The bench holds each bit-clock level for eight system clocks and reads tx_sd only at its own rising edge, well after the bit has settled. Pair flags, interrupts and receive registers settle a few clocks after the last rising edge of the right word, so the bench checks them only after the whole frame has finished. In master mode, periods are counted in system clocks by polling at falling system-clock edges.

// File: rtl/stereo_audio_port.sv
module stereo_audio_port #(
  parameter int NTX     = 5,
  parameter int NRX     = 4,
  parameter int SW      = 24,
  parameter int SLOT    = 32,
  parameter int DIV     = 4,
  parameter int NM      = 2,
  parameter int AW      = 6,
  parameter int TX_BASE = 8,
  parameter int RX_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     hreq,
  input  logic [NM-1:0]     hwe,
  input  logic [NM*AW-1:0]  haddr,
  input  logic [NM*32-1:0]  hwdata,
  output logic [NM-1:0]     hgnt,
  output logic [NM-1:0]     hrvalid,
  output logic [31:0]       hrdata,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              sck_i,
  input  logic              ws_i,
  output logic              sck_o,
  output logic              ws_o,
  output logic              clk_oe,
  output logic [NTX-1:0]    tx_sd,
  input  logic [NRX-1:0]    rx_sd
);
  localparam int BCW = $clog2(2 * SLOT);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SCW = $clog2(SW + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_TXLAST = AW'(TX_BASE + 2 * NTX - 1);
  localparam logic [AW-1:0] A_RXLAST = AW'(RX_BASE + 2 * NRX - 1);

  // host arbitration: lowest index wins
  logic [AW-1:0] a;
  logic [31:0]   wd;
  logic          we_sel;
  always_comb begin
    hgnt = '0;
    for (int m = NM - 1; m >= 0; m--)
      if (hreq[m]) begin
        hgnt    = '0;
        hgnt[m] = 1'b1;
      end
    a = '0; wd = '0; we_sel = 1'b0;
    for (int m = 0; m < NM; m++)
      if (hgnt[m]) begin
        a      = haddr[m*AW +: AW];
        wd     = hwdata[m*32 +: 32];
        we_sel = hwe[m];
      end
  end
  wire acc   = |hreq;
  wire wr    = acc & we_sel;
  wire rd    = acc & ~we_sel;
  wire st_rd = rd && a == A_STAT;

  logic [4:0] ctrl;
  wire tx_en = ctrl[0], rx_en = ctrl[1], master = ctrl[2];

  logic [SW-1:0] txl [NTX];
  logic [SW-1:0] txr [NTX];
  logic [SW-1:0] txh [NTX];
  logic [SW-1:0] txs [NTX];
  logic [SW-1:0] rxl [NRX];
  logic [SW-1:0] rxr [NRX];
  logic [SW-1:0] rxh [NRX];
  logic [SW-1:0] rxs [NRX];
  logic tx_req, rx_rdy, tx_ur, rx_ov;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      for (int i = 0; i < NTX; i++) begin txl[i] <= '0; txr[i] <= '0; end
    end else if (wr) begin
      if (a == A_CTRL) ctrl <= wd[4:0];
      for (int i = 0; i < NTX; i++) begin
        if (a == AW'(TX_BASE + 2 * i))     txl[i] <= wd[SW-1:0];
        if (a == AW'(TX_BASE + 2 * i + 1)) txr[i] <= wd[SW-1:0];
      end
    end

  logic [31:0] rdv;
  always_comb begin
    rdv = '0;
    if (a == A_CTRL) rdv = {27'd0, ctrl};
    if (a == A_STAT) rdv = {28'd0, rx_ov, tx_ur, rx_rdy, tx_req};
    for (int i = 0; i < NTX; i++) begin
      if (a == AW'(TX_BASE + 2 * i))     rdv = 32'(txl[i]);
      if (a == AW'(TX_BASE + 2 * i + 1)) rdv = 32'(txr[i]);
    end
    for (int j = 0; j < NRX; j++) begin
      if (a == AW'(RX_BASE + 2 * j))     rdv = 32'(rxl[j]);
      if (a == AW'(RX_BASE + 2 * j + 1)) rdv = 32'(rxr[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hrdata  <= '0;
      hrvalid <= '0;
    end else begin
      hrvalid <= hgnt & ~hwe;
      if (rd) hrdata <= rdv;
    end

  // clock front end: synchronised inputs or internal divider
  logic [1:0]     sck_s, ws_s;
  logic [NRX-1:0] rx_s1, rx_s2;
  logic [DCW-1:0] dcnt;
  logic           bck, sck_q;
  logic [BCW-1:0] bcnt;
  wire ws_int = bcnt >= BCW'(SLOT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; ws_s <= '0; rx_s1 <= '0; rx_s2 <= '0;
      dcnt <= '0; bck <= 1'b0; bcnt <= '0; sck_q <= 1'b0;
    end else begin
      sck_s <= {sck_s[0], sck_i};
      ws_s  <= {ws_s[0], ws_i};
      rx_s1 <= rx_sd;
      rx_s2 <= rx_s1;
      sck_q <= sck_c;
      if (!master) begin
        dcnt <= '0; bck <= 1'b0; bcnt <= '0;
      end else if (dcnt == DCW'(DIV - 1)) begin
        dcnt <= '0;
        bck  <= ~bck;
        if (bck) bcnt <= (bcnt == BCW'(2 * SLOT - 1)) ? '0 : bcnt + 1'b1;
      end else dcnt <= dcnt + 1'b1;
    end

  logic sck_c, ws_c;
  assign sck_c  = master ? bck : sck_s[1];
  assign ws_c   = master ? ws_int : ws_s[1];
  assign sck_o  = bck;
  assign ws_o   = ws_int;
  assign clk_oe = master;
  wire fall = sck_q & ~sck_c;
  wire rise = ~sck_q & sck_c;

  // serial engine
  logic           wsd, chg, ch;
  logic [SCW-1:0] rcnt;
  wire pair_ld = fall & chg & ~ws_c & tx_en;
  wire last_rx = rise && rcnt == SCW'(SW - 1);
  wire pair_dn = last_rx & ch & rx_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wsd <= 1'b1; chg <= 1'b0; ch <= 1'b0; rcnt <= SCW'(SW);
      for (int i = 0; i < NTX; i++) begin txh[i] <= '0; txs[i] <= '0; end
      for (int j = 0; j < NRX; j++) begin
        rxl[j] <= '0; rxr[j] <= '0; rxh[j] <= '0; rxs[j] <= '0;
      end
    end else if (fall) begin
      wsd <= ws_c;
      chg <= ws_c != wsd;
      if (chg) begin
        rcnt <= '0;
        ch   <= ws_c;
        for (int i = 0; i < NTX; i++)
          if (!tx_en) txs[i] <= '0;
          else if (!ws_c) begin txs[i] <= txl[i]; txh[i] <= txr[i]; end
          else txs[i] <= txh[i];
      end else
        for (int i = 0; i < NTX; i++) txs[i] <= txs[i] << 1;
    end else if (rise && rcnt < SCW'(SW)) begin
      rcnt <= rcnt + 1'b1;
      for (int j = 0; j < NRX; j++) begin
        rxs[j] <= {rxs[j][SW-2:0], rx_s2[j]};
        if (last_rx && rx_en) begin
          if (!ch) rxh[j] <= {rxs[j][SW-2:0], rx_s2[j]};
          else begin
            rxl[j] <= rxh[j];
            rxr[j] <= {rxs[j][SW-2:0], rx_s2[j]};
          end
        end
      end
    end

  always_comb
    for (int i = 0; i < NTX; i++) tx_sd[i] = txs[i][SW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_req <= 1'b1; rx_rdy <= 1'b0; tx_ur <= 1'b0; rx_ov <= 1'b0;
    end else begin
      tx_req <= pair_ld | (tx_req & ~(wr && a == A_TXLAST));
      tx_ur  <= (pair_ld & tx_req) | (tx_ur & ~st_rd);
      rx_rdy <= pair_dn | (rx_rdy & ~(rd && a == A_RXLAST));
      rx_ov  <= (pair_dn & rx_rdy) | (rx_ov & ~st_rd);
    end

  assign tx_irq = ctrl[3] & tx_req;
  assign rx_irq = ctrl[4] & rx_rdy;

  AST_RVALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hrvalid)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fall |=> $stable(tx_sd)); // R4
  AST_UR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_ur) |-> $past(tx_req)); // R8
  AST_RDY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_rdy) |-> $past(rise)); // R9
  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rx_ov && !st_rd |=> rx_ov); // R10
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) master && $changed(ws_o) |-> $fell(sck_o)); // R13
endmodule

// File: tb/test_stereo_audio_port.sv
module test_stereo_audio_port;
  localparam int NTX = 5, NRX = 4, SW = 24, SLOT = 32, DIV = 4, NM = 2, AW = 6;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0] hreq = '0, hwe = '0;
  logic [NM*AW-1:0] haddr = '0;
  logic [NM*32-1:0] hwdata = '0;
  logic [NM-1:0] hgnt, hrvalid;
  logic [31:0] hrdata;
  logic tx_irq, rx_irq, sck_o, ws_o, clk_oe;
  logic sck = 1'b1, ws = 1'b1;
  logic [NTX-1:0] tx_sd;
  logic [NRX-1:0] rxd = '0;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  stereo_audio_port i_stereo_audio_port (
    .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwe(hwe), .haddr(haddr), .hwdata(hwdata),
    .hgnt(hgnt), .hrvalid(hrvalid), .hrdata(hrdata), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .sck_i(sck), .ws_i(ws), .sck_o(sck_o), .ws_o(ws_o), .clk_oe(clk_oe),
    .tx_sd(tx_sd), .rx_sd(rxd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input int m, input int ad, input logic [31:0] d);
    @(negedge clk);
    hreq[m] = 1'b1; hwe[m] = 1'b1; haddr[m*AW +: AW] = AW'(ad); hwdata[m*32 +: 32] = d;
    @(negedge clk);
    hreq[m] = 1'b0; hwe[m] = 1'b0;
  endtask

  task automatic hr(input int m, input int ad, output logic [31:0] d);
    @(negedge clk);
    hreq[m] = 1'b1; hwe[m] = 1'b0; haddr[m*AW +: AW] = AW'(ad);
    @(negedge clk);
    d = hrdata;
    hreq[m] = 1'b0;
  endtask

  function automatic logic [SW-1:0] txval(input int f, input int i, input int c);
    return SW'(f * 24'h2B3C4D + i * 24'h111111 + c * 24'h800001 + 24'h0A5001);
  endfunction
  function automatic logic [SW-1:0] rxval(input int f, input int j, input int c);
    return SW'(f * 24'h13579B + j * 24'h2468A1 + c * 24'h7F0F0F + 24'h00C003);
  endfunction

  logic [SW-1:0] buf_m [NTX][2];
  logic [SW-1:0] sent [NTX][2];
  logic [SW-1:0] got  [NTX][2];
  int stray;

  // one I2S frame of 64 bit clocks, left half then right half
  task automatic run_frame(input int f);
    stray = 0;
    for (int b = 0; b < 2 * SLOT; b++) begin
      int c, pos;
      c = (b >= SLOT) ? 1 : 0;
      pos = b % SLOT;
      sck = 1'b0;
      ws = c[0];
      for (int j = 0; j < NRX; j++) begin
        logic [SW-1:0] w;
        w = rxval(f, j, c);
        rxd[j] = (pos >= 1 && pos <= SW) ? w[SW-pos] : 1'b0;
      end
      repeat (H) @(negedge clk);
      sck = 1'b1;
      for (int i = 0; i < NTX; i++)
        if (pos >= 1 && pos <= SW) got[i][c][SW-pos] = tx_sd[i];
        else if (tx_sd[i]) stray++;
      repeat (H) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic er, erd, eur, eov;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {26'd0, sck_o, ws_o, clk_oe, tx_irq, rx_irq, |tx_sd}, 32'd0);
    chk("R1 grant/valid", {28'd0, hgnt, hrvalid}, 32'd0);
    hr(0, 1, d);
    chk("R1 status", d, 32'h1);

    // R2 arbitration: master 0 reads CTRL while master 1 writes it
    @(negedge clk);
    hreq = 2'b11; hwe = 2'b10; haddr = {AW'(0), AW'(0)}; hwdata = {32'h18, 32'h0};
    #1 chk("R2 grant low index", 32'(hgnt), 32'h1);
    @(negedge clk);
    chk("R2 rvalid to winner", 32'(hrvalid), 32'h1);
    chk("R2 loser ignored", hrdata, 32'h0);
    hreq = 2'b10;
    #1 chk("R2 grant alone", 32'(hgnt), 32'h2);
    @(negedge clk);
    hreq = '0; hwe = '0;
    hr(1, 0, d);
    chk("R2 R3 ctrl write by master 1", d, 32'h18);

    // R3 transmit register readback
    for (int i = 0; i < NTX; i++) begin
      hw(0, 8 + 2 * i, 32'(txval(9, i, 0)));
      hw(1, 9 + 2 * i, 32'hFF000000 | 32'(txval(9, i, 1)));
    end
    for (int i = 0; i < NTX; i++) begin
      hr(1, 8 + 2 * i, d); chk("R3 tx left readback", d, 32'(txval(9, i, 0)));
      hr(0, 9 + 2 * i, d); chk("R3 tx right readback", d, 32'(txval(9, i, 1)));
    end

    hw(0, 0, 32'h1B);
    er = 1'b1; erd = 1'b0; eur = 1'b0; eov = 1'b0;
    for (int f = 0; f < 6; f++) begin
      if (f != 2) begin
        for (int i = 0; i < NTX; i++) begin
          buf_m[i][0] = txval(f, i, 0);
          buf_m[i][1] = txval(f, i, 1);
          hw(f % 2, 8 + 2 * i, 32'(buf_m[i][0]));
          hw(f % 2, 9 + 2 * i, 32'(buf_m[i][1]));
        end
        er = 1'b0;
        @(negedge clk);
        chk("R7 R12 request cleared by last right write", {30'd0, tx_irq, rx_irq}, {30'd0, 1'b0, erd});
      end
      for (int i = 0; i < NTX; i++) begin sent[i][0] = buf_m[i][0]; sent[i][1] = buf_m[i][1]; end
      if (er) eur = 1'b1;
      er = 1'b1;
      run_frame(f);
      if (erd) eov = 1'b1;
      erd = 1'b1;
      repeat (4) @(negedge clk);
      chk("R12 interrupts per pair", {30'd0, tx_irq, rx_irq}, 32'h3);
      chk("R4 no stray bits", stray, 0);
      for (int i = 0; i < NTX; i++)
        for (int c = 0; c < 2; c++)
          chk(c == 0 ? "R4 R6 R7 R8 tx left word" : "R4 R6 R7 R8 tx right word", 32'(got[i][c]), 32'(sent[i][c]));
      hr(f % 2, 1, d);
      chk("R8 R10 R11 status flags", d, {28'd0, eov, eur, erd, er});
      eur = 1'b0; eov = 1'b0;
      if (f != 3) begin
        for (int j = 0; j < NRX; j++)
          for (int c = 0; c < 2; c++) begin
            hr(f % 2, 32 + 2 * j + c, d);
            chk("R5 R6 R10 rx word", d, 32'(rxval(f, j, c)));
          end
        erd = 1'b0;
        hr(0, 1, d);
        chk("R9 R11 status after reads", d, {28'd0, 1'b0, 1'b0, 1'b0, er});
      end
    end

    // R12 gating
    hw(0, 0, 32'h03);
    @(negedge clk);
    chk("R12 interrupts masked", {30'd0, tx_irq, rx_irq}, 32'h0);

    // R13 master clocks
    hw(0, 0, 32'h04);
    @(negedge clk);
    chk("R13 clock output enable", 32'(clk_oe), 32'h1);
    d[0] = sck_o;
    while (sck_o == d[0]) @(negedge clk);
    cnt = 0; d[0] = sck_o;
    while (sck_o == d[0]) begin @(negedge clk); cnt++; end
    chk("R13 bit clock half period", cnt, DIV);
    d[0] = ws_o;
    while (ws_o == d[0]) @(negedge clk);
    chk("R13 word clock moves with falling bit clock", 32'(sck_o), 32'h0);
    cnt = 0; d[0] = ws_o;
    while (ws_o == d[0]) begin @(negedge clk); cnt++; end
    chk("R13 word clock half frame", cnt, 2 * SLOT * DIV);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule